// File: doc/BRIEF.md
# Asynchronous Nonvolatile RAM Access Controller

This block sits between a synchronous host and an external asynchronous RAM of 64K words by 16 bits. The host offers one request at a time on a valid/ready handshake: an address, write data, a per-byte lane mask and a read/write flag. The controller turns each request into a sequence on the memory's active-low chip enable, write enable, output enable and the two byte-lane selects. It also drives the enable of the tristate driver for the shared data bus, and for every request it returns a one-cycle response carrying the read data.

All analog timing limits are given in nanoseconds as parameters and turn into whole clock cycles during elaboration. The conversion is ceil(limit / clock period), with a floor of one cycle. A write runs in three phases (address setup, write pulse, recovery). A read runs in two phases (access, bus release). After reset the controller holds every enable inactive for a power-up quiet period, and it accepts no request before that period ends.

Output enable is never taken low during a write. The controller's own data drivers turn on only after a turnaround delay that covers the time the memory may still drive the bus. This keeps the two sides from ever driving the bus against each other.

Top module: `nvram_ctrl`

## Requirements
- R1: After reset is released, `req_ready` stays low while chip enable and write enable stay high. This lasts for BOOT = ceil(T_BOOT_NS / CLK_NS) cycles; `req_ready` is first seen high one cycle later.
- R2: `req_ready` is high only while the controller is idle and after the quiet period. Whenever it is high, chip enable, write enable and output enable are all high and the data driver is off.
- R3: In a write, output enable stays high throughout. Write enable is low for exactly PULSE = max(ceil(T_WPULSE), ceil(T_ADDR_END) - SETUP, TURN + ceil(T_DSETUP)) cycles. Chip enable is low for SETUP + PULSE cycles, with SETUP = ceil(T_ASETUP) (floor 1).
- R4: The data driver enable (`mem_dq_oe`) goes high only while write enable is low and output enable is high. It goes high no earlier than TURN = ceil(T_RELEASE_NS) cycles after write enable falls, and it stays high until write enable rises: PULSE - TURN cycles.
- R5: Lane mask bit 0 selects the lower byte (data bits 7:0) through `mem_lo_n`, and bit 1 selects the upper byte (bits 15:8) through `mem_hi_n`. A write changes only the selected bytes of the addressed word.
- R6: In a read, chip enable and output enable are low together for exactly ACC = ceil(T_ACCESS_NS) cycles. The response returns the word sampled at the end of that window, with unselected bytes forced to zero.
- R7: A request with an all-zero lane mask never asserts chip enable. It gives a response with zero data in the cycle after it is accepted and leaves the memory contents unchanged.
- R8: The memory address stays stable while chip enable is low. After a write it also stays stable for at least WREC = ceil(T_WREC_NS) cycles after the write ends.
- R9: Between two accesses, chip enable stays high for at least WREC cycles after a write and at least RREC = ceil(T_HIZ_NS) cycles after a read.
- R10: While chip enable is high, both lane selects are high. While chip enable is low, at least one lane select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset; restarts the power-up quiet period |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Byte lane mask, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 16 | Read data (zero for writes and zero-mask requests) |
| mem_addr | output | 16 | Address to the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lo_n | output | 1 | Lower byte select, active low |
| mem_hi_n | output | 1 | Upper byte select, active low |
| mem_dq_out | output | 16 | Data the controller drives onto the bus |
| mem_dq_oe | output | 1 | Enable of the controller's bus drivers |
| mem_dq_in | input | 16 | Data read from the bus |

## Verification
The access sequencer runs with directed word, lower-only and upper-only writes and reads at the lowest and highest addresses. This shows whether lane selects reach the right byte and whether the masking on reads is correct. A zero-mask request tells a controller that skips the memory apart from one that runs an empty cycle. Seeded random sequences of mixed reads and writes over a small address pool, compared against a shadow memory, catch stale data and cross-address corruption. The same sequences measure every phase width, driver window and enable gap against the cycle counts worked out from the nanosecond limits.

// File: rtl/nvram_pkg.sv
// Package: shared state encoding and the nanosecond-to-cycle conversion
// used by the asynchronous RAM controller and its checker.
package nvram_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WRECOV,
        ST_RACCESS,
        ST_RRECOV
    } nv_state_e;

    // Ceiling of ns/period, never below one cycle.
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        if (ns <= 0) return 1;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nvram_phase_timer.sv
// Phase timer: counts the cycles spent in the current sequencer phase.
// Assumes the owner pulses `restart` in the cycle before a new phase
// begins; the count saturates so it never wraps in long idle periods.
module nvram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] elapsed
);
    // Clear on phase change, otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            elapsed <= '0;
        else if (elapsed != {CNT_W{1'b1}})
            elapsed <= elapsed + 1'b1;
    end
endmodule

// File: rtl/nvram_boot_hold.sv
// Power-up hold: raises `boot_done` after BOOT_C clock cycles from reset.
// Assumes reset is applied at power-up and after any supply-low event.
module nvram_boot_hold #(
    parameter int BOOT_C = 400000
) (
    input  logic clk,
    input  logic rst_n,
    output logic boot_done
);
    localparam int CW = $clog2(BOOT_C + 1) + 1;

    logic [CW-1:0] count;

    // Count quiet cycles until the limit, then hold done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            boot_done <= 1'b0;
        end else if (!boot_done) begin
            count     <= count + 1'b1;
            boot_done <= (count == CW'(BOOT_C - 1));
        end
    end
endmodule

// File: rtl/nvram_ctrl.sv
// Asynchronous 64K x 16 nonvolatile RAM controller.
// Turns host requests into chip/write/output-enable and lane-select
// sequences whose phase lengths come from nanosecond parameters. Assumes
// one request in flight at a time and an external tristate buffer that
// follows mem_dq_oe. Memory control outputs are decoded from state.
module nvram_ctrl
    import nvram_pkg::*;
#(
    parameter int CLK_NS      = 5,
    parameter int T_CYCLE_NS  = 35,
    parameter int T_ACCESS_NS = 35,
    parameter int T_ASETUP_NS = 0,
    parameter int T_WPULSE_NS = 15,
    parameter int T_ADDR_END_NS = 18,
    parameter int T_DSETUP_NS = 10,
    parameter int T_WREC_NS   = 12,
    parameter int T_RELEASE_NS = 12,
    parameter int T_HIZ_NS    = 15,
    parameter int T_BOOT_NS   = 2000000,
    parameter int ADDR_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_lanes,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lo_n,
    output logic              mem_hi_n,
    output logic [15:0]       mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_in
);
    localparam int LANES   = 2;
    localparam int SETUP_C = ns_to_cyc(T_ASETUP_NS, CLK_NS);
    localparam int TA_C    = ns_to_cyc(T_RELEASE_NS, CLK_NS);
    localparam int PULSE_C = imax(imax(ns_to_cyc(T_WPULSE_NS, CLK_NS),
                                       ns_to_cyc(T_ADDR_END_NS, CLK_NS) - SETUP_C),
                                  TA_C + ns_to_cyc(T_DSETUP_NS, CLK_NS));
    localparam int WREC_C  = imax(ns_to_cyc(T_WREC_NS, CLK_NS),
                                  ns_to_cyc(T_CYCLE_NS, CLK_NS) - SETUP_C - PULSE_C);
    localparam int ACC_C   = imax(ns_to_cyc(T_ACCESS_NS, CLK_NS),
                                  ns_to_cyc(T_CYCLE_NS, CLK_NS));
    localparam int RREC_C  = ns_to_cyc(T_HIZ_NS, CLK_NS);
    localparam int BOOT_C  = ns_to_cyc(T_BOOT_NS, CLK_NS);
    localparam int MAXPH   = imax(imax(SETUP_C, PULSE_C), imax(imax(WREC_C, ACC_C), RREC_C));
    localparam int CNT_W   = $clog2(MAXPH + 1) + 1;

    nv_state_e          state, state_next;
    logic [CNT_W-1:0]   elapsed;
    logic               boot_done;
    logic               accept;
    logic               phase_end;
    logic [LANES-1:0]   lat_lanes;
    logic [15:0]        read_masked;

    nvram_boot_hold #(.BOOT_C(BOOT_C)) i_boot (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_done (boot_done)
    );

    nvram_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_next != state),
        .elapsed (elapsed)
    );

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;

    // Detect the last cycle of the current timed phase.
    always_comb begin
        unique case (state)
            ST_WSETUP:  phase_end = (elapsed == CNT_W'(SETUP_C - 1));
            ST_WPULSE:  phase_end = (elapsed == CNT_W'(PULSE_C - 1));
            ST_WRECOV:  phase_end = (elapsed == CNT_W'(WREC_C - 1));
            ST_RACCESS: phase_end = (elapsed == CNT_W'(ACC_C - 1));
            ST_RRECOV:  phase_end = (elapsed == CNT_W'(RREC_C - 1));
            default:    phase_end = 1'b0;
        endcase
    end

    // Choose the next sequencer phase.
    always_comb begin
        state_next = state;
        unique case (state)
            ST_BOOT:    if (boot_done) state_next = ST_IDLE;
            ST_IDLE:    if (accept && (req_lanes != '0))
                            state_next = req_write ? ST_WSETUP : ST_RACCESS;
            ST_WSETUP:  if (phase_end) state_next = ST_WPULSE;
            ST_WPULSE:  if (phase_end) state_next = ST_WRECOV;
            ST_WRECOV:  if (phase_end) state_next = ST_IDLE;
            ST_RACCESS: if (phase_end) state_next = ST_RRECOV;
            ST_RRECOV:  if (phase_end) state_next = ST_IDLE;
            default:    state_next = ST_BOOT;
        endcase
    end

    // Advance the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_BOOT;
        else        state <= state_next;
    end

    // Capture the request fields on acceptance and hold them for the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            lat_lanes  <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
            lat_lanes  <= req_lanes;
        end
    end

    // Zero the bytes of unselected lanes in the sampled read word.
    for (genvar g = 0; g < LANES; g++) begin : g_lane_mask
        assign read_masked[g*8 +: 8] = lat_lanes[g] ? mem_dq_in[g*8 +: 8] : 8'h00;
    end

    // Produce the one-cycle response and the returned data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept && (req_lanes == '0)) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= '0;
            end else if (state == ST_RACCESS && phase_end) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= read_masked;
            end else if (state == ST_WRECOV && phase_end) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= '0;
            end
        end
    end

    // Decode the memory control pins from the current phase.
    always_comb begin
        logic sel;
        sel        = (state == ST_WSETUP) || (state == ST_WPULSE) || (state == ST_RACCESS);
        mem_ce_n   = !sel;
        mem_we_n   = (state != ST_WPULSE);
        mem_oe_n   = (state != ST_RACCESS);
        mem_lo_n   = !(sel && lat_lanes[0]);
        mem_hi_n   = !(sel && lat_lanes[1]);
        mem_dq_oe  = (state == ST_WPULSE) && (elapsed >= CNT_W'(TA_C));
    end

endmodule

// File: rtl/nvram_ctrl_chk.sv
// Checker for nvram_ctrl: watches the memory pins and host handshake and
// measures phase widths with its own counters. Assumes the derived cycle
// counts are passed in from the bound instance.
module nvram_ctrl_chk #(
    parameter int TA_C    = 3,
    parameter int PULSE_C = 5,
    parameter int ACC_C   = 7,
    parameter int BOOT_C  = 100,
    parameter int ADDR_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_lo_n,
    input logic              mem_hi_n,
    input logic              mem_dq_oe
);
    localparam int BW = $clog2(BOOT_C + 1) + 1;

    logic [BW-1:0] boot_cnt;
    logic [7:0]    we_low_cnt;
    logic [7:0]    oe_low_cnt;

    // Track cycles since reset, saturating at the quiet-period length.
    always_ff @(posedge clk) begin
        if (!rst_n)                       boot_cnt <= '0;
        else if (boot_cnt != BW'(BOOT_C)) boot_cnt <= boot_cnt + 1'b1;
    end

    // Track how long write enable and output enable have been low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
            oe_low_cnt <= '0;
        end else begin
            we_low_cnt <= mem_we_n ? 8'd0 : we_low_cnt + 8'd1;
            oe_low_cnt <= mem_oe_n ? 8'd0 : oe_low_cnt + 8'd1;
        end
    end

    p_boot_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_cnt < BW'(BOOT_C)) |-> (mem_ce_n && mem_we_n && !req_ready));

    p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    p_oe_high_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt == 8'(PULSE_C)));

    p_drive_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n && we_low_cnt >= 8'(TA_C)));

    p_read_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_low_cnt == 8'(ACC_C)));

    p_zero_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !(mem_lo_n && mem_hi_n));

    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    p_lane_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_lo_n && mem_hi_n));

endmodule

bind nvram_ctrl nvram_ctrl_chk #(
    .TA_C    (TA_C),
    .PULSE_C (PULSE_C),
    .ACC_C   (ACC_C),
    .BOOT_C  (BOOT_C),
    .ADDR_W  (ADDR_W)
) i_nvram_ctrl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_lo_n  (mem_lo_n),
    .mem_hi_n  (mem_hi_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_nvram_ctrl.sv
`timescale 1ns/1ps
// Bench for nvram_ctrl: behavioural asynchronous RAM model, directed and
// seeded random requests, a shadow memory and a pin-timing monitor.
module test_nvram_ctrl;

    localparam int CLK_NS    = 5;
    localparam int T_BOOT_NS = 500;

    // Expected cycle counts worked out from the requirements.
    function automatic int cyc(input int ns);
        int c;
        if (ns <= 0) return 1;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_SETUP = cyc(0);
    localparam int E_TURN  = cyc(12);
    localparam int E_PULSE = mx(mx(cyc(15), cyc(18) - E_SETUP), E_TURN + cyc(10));
    localparam int E_WREC  = mx(cyc(12), cyc(35) - E_SETUP - E_PULSE);
    localparam int E_ACC   = cyc(35);
    localparam int E_RREC  = cyc(15);
    localparam int E_BOOT  = cyc(T_BOOT_NS);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_lanes = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [15:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lo_n, mem_hi_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in;

    int checks = 0;
    int errors = 0;
    logic running = 1'b0;

    always #2.5 clk = ~clk;

    nvram_ctrl #(.CLK_NS(CLK_NS), .T_BOOT_NS(T_BOOT_NS)) i_nvram_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_lanes(req_lanes),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lo_n(mem_lo_n), .mem_hi_n(mem_hi_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [15:0] model [int];
    logic [15:0] shadow [int];
    logic        pend = 1'b0;
    logic [15:0] p_addr, p_data;
    logic        p_lo, p_hi, p_drv;

    function automatic logic [15:0] mread(input logic [15:0] a);
        return model.exists(int'(a)) ? model[int'(a)] : 16'h0000;
    endfunction

    // Memory drives the bus only when selected for a read.
    always_comb begin
        logic [15:0] w;
        w = mread(mem_addr);
        mem_dq_in = 16'hzzzz;
        if (!mem_ce_n && mem_we_n && !mem_oe_n) begin
            if (!mem_lo_n) mem_dq_in[7:0]  = w[7:0];
            if (!mem_hi_n) mem_dq_in[15:8] = w[15:8];
        end
    end

    // Write happens during ce/we overlap and commits when it ends.
    always @(posedge clk) begin
        if (!mem_ce_n && !mem_we_n) begin
            pend   <= 1'b1;
            p_addr <= mem_addr;
            p_data <= mem_dq_out;
            p_lo   <= !mem_lo_n;
            p_hi   <= !mem_hi_n;
            p_drv  <= mem_dq_oe;
        end else if (pend) begin
            logic [15:0] w;
            pend <= 1'b0;
            w = mread(p_addr);
            if (p_lo) w[7:0]  = p_data[7:0];
            if (p_hi) w[15:8] = p_data[15:8];
            model[int'(p_addr)] = w;
            chk(p_drv, "R4 data driven at end of write", int'(p_drv), 1);
        end
    end

    // ---------------- pin timing monitor ----------------
    logic        prev_ce = 1'b1, prev_we = 1'b1;
    int          ce_low = 0, ce_high = 1000, we_low = 0, dq_hi = 0;
    logic        acc_wr = 1'b0, last_wr = 1'b0, seen = 1'b0;
    logic        oe_bad = 1'b0, addr_bad = 1'b0, lane_bad = 1'b0;
    logic [15:0] addr_hold = '0;
    int          ce_falls = 0;

    always @(negedge clk) begin
        if (running) begin
            if (!mem_ce_n) begin
                if (prev_ce) begin
                    if (seen)
                        chk(ce_high >= (last_wr ? E_WREC : E_RREC), "R9 ce high gap",
                            ce_high, last_wr ? E_WREC : E_RREC);
                    ce_falls++;
                    addr_hold = mem_addr;
                    ce_low    = 0;
                    acc_wr    = 1'b0;
                    addr_bad  = 1'b0;
                end
                ce_low++;
                if (mem_addr != addr_hold) addr_bad = 1'b1;
                if (mem_lo_n && mem_hi_n) lane_bad = 1'b1;
                if (!mem_we_n) acc_wr = 1'b1;
            end else begin
                if (!prev_ce) begin
                    chk(ce_low == (acc_wr ? E_SETUP + E_PULSE : E_ACC),
                        acc_wr ? "R3 ce low width" : "R6 ce low width",
                        ce_low, acc_wr ? E_SETUP + E_PULSE : E_ACC);
                    chk(!lane_bad, "R10 lane select with ce low", int'(lane_bad), 0);
                    last_wr = acc_wr;
                    seen    = 1'b1;
                    ce_high = 0;
                end
                if (last_wr && ce_high < E_WREC && mem_addr != addr_hold) addr_bad = 1'b1;
                ce_high++;
                if (ce_high == E_WREC)
                    chk(!addr_bad, "R8 address stable", int'(mem_addr), int'(addr_hold));
                if (!(mem_lo_n && mem_hi_n)) lane_bad = 1'b1;
            end
            if (!mem_we_n) begin
                we_low++;
                if (mem_dq_oe) dq_hi++;
                if (!mem_oe_n) oe_bad = 1'b1;
            end else if (!prev_we) begin
                chk(we_low == E_PULSE, "R3 write pulse width", we_low, E_PULSE);
                chk(!oe_bad, "R3 oe high in write", int'(oe_bad), 0);
                chk(dq_hi == E_PULSE - E_TURN, "R4 driver window", dq_hi, E_PULSE - E_TURN);
                we_low = 0; dq_hi = 0; oe_bad = 1'b0;
            end
            if (mem_dq_oe && (mem_we_n || !mem_oe_n)) begin
                checks++; errors++;
                $display("FAIL R4 driver outside write pulse actual=1 expected=0");
            end
            prev_ce = mem_ce_n;
            prev_we = mem_we_n;
        end
    end

    // ---------------- host tasks ----------------
    task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] ln, output logic [15:0] rd);
        while (!req_ready) @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R2 pins idle while ready",
            {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_lanes = ln;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        rd = rsp_rdata;
        @(negedge clk);
    endtask

    function automatic logic [15:0] lmask(input logic [1:0] ln);
        return {{8{ln[1]}}, {8{ln[0]}}};
    endfunction

    task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] ln);
        logic [15:0] rd, old;
        issue(1'b1, a, d, ln, rd);
        old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
        shadow[int'(a)] = (old & ~lmask(ln)) | (d & lmask(ln));
        chk(rd == 16'h0000, "R5 write response data", int'(rd), 0);
    endtask

    task automatic do_read(input logic [15:0] a, input logic [1:0] ln, input string tag);
        logic [15:0] rd, exp;
        issue(1'b0, a, 16'h0000, ln, rd);
        exp = (shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000) & lmask(ln);
        chk(rd == exp, tag, int'(rd), int'(exp));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int lowcnt;
        int falls0;
        logic [15:0] rd;
        logic [15:0] pool [16];
        void'($urandom(32'd24601));
        repeat (3) @(negedge clk);
        chk(!req_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
            "R1 reset state", {req_ready, mem_ce_n, mem_we_n, mem_oe_n}, 4'b0111);
        rst_n = 1'b1;
        running = 1'b1;
        lowcnt = 0;
        @(negedge clk);
        while (!req_ready && lowcnt < E_BOOT + 10) begin
            if (!(mem_ce_n && mem_we_n)) begin
                checks++; errors++;
                $display("FAIL R1 enable during quiet period actual=0 expected=1");
            end
            lowcnt++;
            @(negedge clk);
        end
        chk(lowcnt == E_BOOT, "R1 quiet period length", lowcnt, E_BOOT);

        // Directed corners at the lowest and highest addresses.
        do_write(16'h0000, 16'hA55A, 2'b11);
        do_read (16'h0000, 2'b11, "R6 full word read");
        do_write(16'hFFFF, 16'h1234, 2'b11);
        do_write(16'hFFFF, 16'hBEEF, 2'b01);
        do_read (16'hFFFF, 2'b11, "R5 lower-only write");
        do_write(16'hFFFF, 16'hC0DE, 2'b10);
        do_read (16'hFFFF, 2'b11, "R5 upper-only write");
        do_read (16'hFFFF, 2'b10, "R6 upper-only read zeroes lower");
        do_read (16'h0000, 2'b01, "R6 lower-only read zeroes upper");

        // Zero lane mask: no chip enable, immediate response, no change.
        falls0 = ce_falls;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0000;
        req_wdata = 16'hFFFF; req_lanes = 2'b00;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid && rsp_rdata == 16'h0000, "R7 zero-mask response next cycle",
            int'(rsp_valid), 1);
        repeat (4) @(negedge clk);
        chk(ce_falls == falls0, "R7 no chip enable for zero mask", ce_falls, falls0);
        do_read(16'h0000, 2'b11, "R7 memory unchanged after zero mask");
        issue(1'b0, 16'hFFFF, 16'h0000, 2'b00, rd);
        chk(rd == 16'h0000 && ce_falls == falls0 + 1, "R7 zero-mask read", int'(rd), 0);

        // Seeded random mix over a small address pool.
        foreach (pool[i]) pool[i] = 16'($urandom);
        for (int n = 0; n < 80; n++) begin
            logic [15:0] a;
            logic [1:0]  ln;
            a  = pool[$urandom % 16];
            ln = 2'($urandom % 4);
            if (ln == 2'b00) ln = 2'b11;
            if ($urandom % 2) do_write(a, 16'($urandom), ln);
            else              do_read(a, ln, "R6 random read vs shadow");
        end
        foreach (pool[i]) do_read(pool[i], 2'b11, "R5 final pool sweep");

        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule